// File: doc/BRIEF.md
# Forwarding Address Table Engine

This block keeps a small table of forwarding entries for a switch. Each entry holds a station MAC address, a VLAN ID, a membership mask over seven ports and a 4-bit status. Software reaches the table through four 32-bit registers. Three data words hold one entry image, and a function word starts a command and reports the result.

To run a command, software writes an entry image into the data words. It then writes the function word with its start/busy bit set and polls until that bit drops. The engine walks every table slot once, one per clock, and then applies the result in one final cycle. A load adds or replaces an entry. A purge removes the entry that matches on MAC and VLAN. A flush empties the whole table. A get-next lets software walk through the valid entries in order, and it can be restricted to entries that include one chosen port. The table lives in flops, and its size is a parameter.

Top module: `atu_engine`

## Requirements
- R1: After synchronous reset, all three data words and the function word read zero and every table slot is empty.
- R2: An entry image places the MAC in image bits [47:0], with MAC byte 5 in word 0 bits [7:0] and byte 0 in word 1 bits [15:8]. The port mask sits in bits [54:48], the status in bits [67:64] and the VLAN ID in bits [83:72], where image bits [95:0] are {word2, word1, word0}. A returned entry leaves all other bits zero.
- R3: A write of the function word (select 3) with bit 31 set starts a command. Bit 31 reads as one until the command ends, and it drops exactly DEPTH+1 clock edges after the starting write. A function-word write with bit 31 clear has no effect.
- R4: Load (command code 2) with a nonzero status writes the image into the lowest-numbered empty slot. A load whose MAC and VLAN match a valid entry overwrites that entry in place and uses no new slot. A status of 0 means empty, and 0xF (static) is stored like any other value.
- R5: A load that finds neither a match nor an empty slot changes nothing and sets bit 12 of the function word. The next started command clears bit 12.
- R6: Purge (code 3) empties the valid entry whose MAC and VLAN match the image. It leaves all other entries unchanged, and a purge with no match changes nothing.
- R7: Flush (code 1) empties every slot.
- R8: Get-next (code 4) with an all-zero MAC and VLAN returns the lowest-numbered valid entry. Otherwise it returns the first valid entry in a higher slot than the entry matching the image. If no such entry exists, or the image matches no entry, it returns an all-zero image.
- R9: When function bit 4 is set, get-next skips entries whose port mask lacks the port numbered by function bits [10:8].
- R10: While bit 31 is set, writes to any register are ignored.
- R11: Any other command code completes with the same timing and changes neither the table nor the data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select: 0..2 data words, 3 function word |
| host_wdata | input | 32 | Register write data |
| data_w0 | output | 32 | Data word 0 |
| data_w1 | output | 32 | Data word 1 |
| data_w2 | output | 32 | Data word 2 |
| func_word | output | 32 | Function word: [31] busy, [12] full, [10:8] port, [4] port filter, [3:0] command |

## Verification
On every cycle, the assertions check the following. A started command keeps busy high until the scan ends. The data words hold still during a command except for the one get-next write-back. The full flag rises only after a load. A new command is accepted only when the scanner is idle. A flush leaves the slots empty, and no single cycle both writes one slot and clears all slots. Only the bench scenarios can show the table's contents and the order of iteration. These include slot reuse after a purge, in-place overwrite, the full condition, which entries the port filter skips, the exact latency, and the ignored writes.

// File: rtl/atu_pkg.sv
package atu_pkg;
    localparam int MAC_W  = 48;
    localparam int VID_W  = 12;
    localparam int PORT_N = 7;
    localparam int STAT_W = 4;
    localparam int WORD_W = 32;
    localparam int PNUM_W = 3;
    localparam int NWORDS = 3;

    localparam int FN_BUSY = 31;
    localparam int FN_FULL = 12;
    localparam int FN_PEN  = 4;

    localparam logic [STAT_W-1:0] STAT_EMPTY  = 4'h0;
    localparam logic [STAT_W-1:0] STAT_STATIC = 4'hF;

    localparam logic [3:0] CMD_FLUSH = 4'd1;
    localparam logic [3:0] CMD_LOAD  = 4'd2;
    localparam logic [3:0] CMD_PURGE = 4'd3;
    localparam logic [3:0] CMD_NEXT  = 4'd4;

    typedef struct packed {
        logic [VID_W-1:0]  vid;
        logic [STAT_W-1:0] status;
        logic [PORT_N-1:0] ports;
        logic [MAC_W-1:0]  mac;
    } atu_entry_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} atu_state_e;

    function automatic atu_entry_t unpack_image(input logic [WORD_W-1:0] w0,
                                                input logic [WORD_W-1:0] w1,
                                                input logic [WORD_W-1:0] w2);
        atu_entry_t e;
        e.mac    = {w1[15:0], w0};
        e.ports  = w1[22:16];
        e.status = w2[3:0];
        e.vid    = w2[19:8];
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input atu_entry_t e, input int n);
        logic [WORD_W-1:0] w;
        case (n)
            0:       w = e.mac[31:0];
            1:       w = {9'b0, e.ports, e.mac[47:32]};
            default: w = {12'b0, e.vid, 4'b0, e.status};
        endcase
        return w;
    endfunction

    function automatic logic entry_live(input atu_entry_t e);
        return e.status != STAT_EMPTY;
    endfunction
endpackage

// File: rtl/atu_table.sv
module atu_table
    import atu_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_idx,
    output atu_entry_t      rd_entry,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  atu_entry_t      wr_entry,
    input  logic            clr_all
);
    atu_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                slots[g] <= '0;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                slots[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = slots[rd_idx];

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (slots[0].status == STAT_EMPTY));

    // R4
    write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_all));
endmodule

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              done,
    input  logic              done_full,
    input  logic              ret_en,
    input  atu_entry_t        ret_entry,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2,
    output logic [WORD_W-1:0] func_word,
    output logic              start,
    output logic              busy,
    output logic [3:0]        cmd,
    output logic              port_en,
    output logic [PNUM_W-1:0] port_num
);
    logic [WORD_W-1:0] dw [NWORDS];
    logic              full_q;
    logic              accept;

    assign accept = host_we && !busy;
    assign start  = accept && host_sel == 2'd3 && host_wdata[FN_BUSY];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                dw[g] <= '0;
            end else if (ret_en) begin
                dw[g] <= pack_word(ret_entry, g);
            end else if (accept && host_sel == 2'(g)) begin
                dw[g] <= host_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            full_q   <= 1'b0;
            cmd      <= '0;
            port_en  <= 1'b0;
            port_num <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            full_q   <= 1'b0;
            cmd      <= host_wdata[3:0];
            port_en  <= host_wdata[FN_PEN];
            port_num <= host_wdata[10:8];
        end else if (done) begin
            busy     <= 1'b0;
            full_q   <= done_full;
        end
    end

    assign word0     = dw[0];
    assign word1     = dw[1];
    assign word2     = dw[2];
    assign func_word = {busy, 18'b0, full_q, 1'b0, port_num, 3'b0, port_en, cmd};

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R10
    words_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ret_en) |=> $stable({dw[0], dw[1], dw[2]}));

    // R5
    full_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> (cmd == CMD_LOAD));
endmodule

// File: rtl/atu_ctrl.sv
module atu_ctrl
    import atu_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        cmd,
    input  logic              port_en,
    input  logic [PNUM_W-1:0] port_num,
    input  atu_entry_t        key,
    output logic [IDXW-1:0]   rd_idx,
    input  atu_entry_t        rd_entry,
    output logic              tbl_we,
    output logic [IDXW-1:0]   tbl_widx,
    output atu_entry_t        tbl_wentry,
    output logic              tbl_clr,
    output logic              done,
    output logic              done_full,
    output logic              ret_en,
    output atu_entry_t        ret_entry
);
    localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

    atu_state_e      state;
    logic [IDXW-1:0] idx;
    logic            armed;
    logic            hit_found, match_found, free_found;
    logic [IDXW-1:0] hit_idx, match_idx, free_idx;

    logic            live, key_match, port_ok;
    logic [7:0]      port_vec;

    assign live      = entry_live(rd_entry);
    assign key_match = live && rd_entry.mac == key.mac && rd_entry.vid == key.vid;
    assign port_vec  = {1'b0, rd_entry.ports};
    assign port_ok   = !port_en || port_vec[port_num];
    assign rd_idx    = (state == ST_FIN) ? hit_idx : idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx         <= '0;
            armed       <= 1'b0;
            hit_found   <= 1'b0;
            match_found <= 1'b0;
            free_found  <= 1'b0;
            hit_idx     <= '0;
            match_idx   <= '0;
            free_idx    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_SCAN;
                        idx         <= '0;
                        armed       <= (key.mac == '0) && (key.vid == '0);
                        hit_found   <= 1'b0;
                        match_found <= 1'b0;
                        free_found  <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (key_match && !match_found) begin
                        match_found <= 1'b1;
                        match_idx   <= idx;
                    end
                    if (!live && !free_found) begin
                        free_found <= 1'b1;
                        free_idx   <= idx;
                    end
                    if (armed && live && port_ok && !hit_found) begin
                        hit_found <= 1'b1;
                        hit_idx   <= idx;
                    end
                    if (key_match) begin
                        armed <= 1'b1;
                    end
                    if (idx == LAST) begin
                        state <= ST_FIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tbl_we     = 1'b0;
        tbl_widx   = '0;
        tbl_wentry = '0;
        tbl_clr    = 1'b0;
        done       = 1'b0;
        done_full  = 1'b0;
        ret_en     = 1'b0;
        ret_entry  = '0;
        if (state == ST_FIN) begin
            done = 1'b1;
            case (cmd)
                CMD_LOAD: begin
                    if (match_found) begin
                        tbl_we     = 1'b1;
                        tbl_widx   = match_idx;
                        tbl_wentry = key;
                    end else if (free_found) begin
                        tbl_we     = 1'b1;
                        tbl_widx   = free_idx;
                        tbl_wentry = key;
                    end else begin
                        done_full  = 1'b1;
                    end
                end
                CMD_PURGE: begin
                    if (match_found) begin
                        tbl_we   = 1'b1;
                        tbl_widx = match_idx;
                    end
                end
                CMD_FLUSH: tbl_clr = 1'b1;
                CMD_NEXT: begin
                    ret_en    = 1'b1;
                    ret_entry = hit_found ? rd_entry : '0;
                end
                default: ;
            endcase
        end
    end

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (state == ST_IDLE));
endmodule

// File: rtl/atu_engine.sv
module atu_engine
    import atu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] data_w0,
    output logic [31:0] data_w1,
    output logic [31:0] data_w2,
    output logic [31:0] func_word
);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              start, busy, port_en;
    logic [3:0]        cmd;
    logic [PNUM_W-1:0] port_num;
    logic              done, done_full, ret_en;
    atu_entry_t        ret_entry, key, rd_entry, tbl_wentry;
    logic [IDXW-1:0]   rd_idx, tbl_widx;
    logic              tbl_we, tbl_clr;

    atu_regfile u_regs (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .done(done), .done_full(done_full), .ret_en(ret_en), .ret_entry(ret_entry),
        .word0(data_w0), .word1(data_w1), .word2(data_w2), .func_word(func_word),
        .start(start), .busy(busy), .cmd(cmd), .port_en(port_en), .port_num(port_num)
    );

    assign key = unpack_image(data_w0, data_w1, data_w2);

    atu_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst),
        .start(start), .cmd(cmd), .port_en(port_en), .port_num(port_num), .key(key),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wentry(tbl_wentry), .tbl_clr(tbl_clr),
        .done(done), .done_full(done_full), .ret_en(ret_en), .ret_entry(ret_entry)
    );

    atu_table #(.DEPTH(DEPTH)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_entry(tbl_wentry), .clr_all(tbl_clr)
    );

    // R10
    no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
endmodule

// File: tb/test_atu_engine.sv
module test_atu_engine;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  cmd;
        logic        pen;
        logic [2:0]  pnum;
        logic [47:0] mac;
        logic [11:0] vid;
        logic [6:0]  pm;
        logic [3:0]  st;
        logic        xfull;
        logic [47:0] xmac;
        logic [11:0] xvid;
        logic [6:0]  xpm;
        logic [3:0]  xst;
    } vec_t;

    localparam logic [47:0] MA = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] MB = 48'h020000000002;
    localparam logic [47:0] MC = 48'h020000000003;
    localparam logic [47:0] MD = 48'h020000000004;
    localparam logic [47:0] ME = 48'h020000000005;
    localparam logic [47:0] MZ = 48'h020000000099;
    localparam logic [47:0] M0 = 48'h0;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  4'd2, 1'b0, 3'd0, MA, 12'd1, 7'h02, 4'hF, 1'b0, MA, 12'd1, 7'h02, 4'hF}, // R4
        '{4'd4,  4'd2, 1'b0, 3'd0, MB, 12'd1, 7'h04, 4'h7, 1'b0, MB, 12'd1, 7'h04, 4'h7}, // R4
        '{4'd4,  4'd2, 1'b0, 3'd0, MC, 12'd2, 7'h02, 4'hF, 1'b0, MC, 12'd2, 7'h02, 4'hF}, // R4
        '{4'd8,  4'd4, 1'b0, 3'd0, M0, 12'd0, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h02, 4'hF}, // R8
        '{4'd8,  4'd4, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, MB, 12'd1, 7'h04, 4'h7}, // R8
        '{4'd8,  4'd4, 1'b0, 3'd0, MB, 12'd1, 7'h00, 4'h0, 1'b0, MC, 12'd2, 7'h02, 4'hF}, // R8
        '{4'd8,  4'd4, 1'b0, 3'd0, MC, 12'd2, 7'h00, 4'h0, 1'b0, M0, 12'd0, 7'h00, 4'h0}, // R8
        '{4'd4,  4'd2, 1'b0, 3'd0, MB, 12'd1, 7'h08, 4'h3, 1'b0, MB, 12'd1, 7'h08, 4'h3}, // R4
        '{4'd4,  4'd4, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, MB, 12'd1, 7'h08, 4'h3}, // R4
        '{4'd4,  4'd2, 1'b0, 3'd0, MD, 12'd3, 7'h20, 4'hF, 1'b0, MD, 12'd3, 7'h20, 4'hF}, // R4
        '{4'd5,  4'd2, 1'b0, 3'd0, ME, 12'd3, 7'h10, 4'hF, 1'b1, ME, 12'd3, 7'h10, 4'hF}, // R5
        '{4'd6,  4'd3, 1'b0, 3'd0, MB, 12'd1, 7'h00, 4'h0, 1'b0, MB, 12'd1, 7'h00, 4'h0}, // R6
        '{4'd6,  4'd4, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, MC, 12'd2, 7'h02, 4'hF}, // R6
        '{4'd4,  4'd2, 1'b0, 3'd0, ME, 12'd3, 7'h10, 4'hF, 1'b0, ME, 12'd3, 7'h10, 4'hF}, // R4
        '{4'd4,  4'd4, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, ME, 12'd3, 7'h10, 4'hF}, // R4
        '{4'd9,  4'd4, 1'b1, 3'd1, M0, 12'd0, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h02, 4'hF}, // R9
        '{4'd9,  4'd4, 1'b1, 3'd1, MA, 12'd1, 7'h00, 4'h0, 1'b0, MC, 12'd2, 7'h02, 4'hF}, // R9
        '{4'd9,  4'd4, 1'b1, 3'd1, MC, 12'd2, 7'h00, 4'h0, 1'b0, M0, 12'd0, 7'h00, 4'h0}, // R9
        '{4'd8,  4'd4, 1'b0, 3'd0, MZ, 12'd9, 7'h00, 4'h0, 1'b0, M0, 12'd0, 7'h00, 4'h0}, // R8
        '{4'd6,  4'd3, 1'b0, 3'd0, MZ, 12'd9, 7'h00, 4'h0, 1'b0, MZ, 12'd9, 7'h00, 4'h0}, // R6
        '{4'd6,  4'd4, 1'b0, 3'd0, M0, 12'd0, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h02, 4'hF}, // R6
        '{4'd5,  4'd2, 1'b0, 3'd0, MA, 12'd2, 7'h01, 4'hF, 1'b1, MA, 12'd2, 7'h01, 4'hF}, // R5
        '{4'd11, 4'd7, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h00, 4'h0}, // R11
        '{4'd11, 4'd4, 1'b0, 3'd0, M0, 12'd0, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h02, 4'hF}, // R11
        '{4'd7,  4'd1, 1'b0, 3'd0, MA, 12'd1, 7'h00, 4'h0, 1'b0, MA, 12'd1, 7'h00, 4'h0}, // R7
        '{4'd7,  4'd4, 1'b0, 3'd0, M0, 12'd0, 7'h00, 4'h0, 1'b0, M0, 12'd0, 7'h00, 4'h0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] data_w0, data_w1, data_w2, func_word;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    atu_engine #(.DEPTH(DEPTH)) i_atu_engine (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .data_w0(data_w0), .data_w1(data_w1), .data_w2(data_w2), .func_word(func_word)
    );

    function automatic logic [95:0] img(input logic [47:0] mac, input logic [11:0] vid,
                                        input logic [6:0] pm, input logic [3:0] st);
        return {12'b0, vid, 4'b0, st, 9'b0, pm, mac};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = data;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_image(input logic [95:0] im);
        wr(2'd0, im[31:0]);
        wr(2'd1, im[63:32]);
        wr(2'd2, im[95:64]);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (func_word[31] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [3:0] cmd, input logic pen, input logic [2:0] pnum,
                       output int cyc);
        wr(2'd3, 32'h8000_0000 | (32'(pnum) << 8) | (32'(pen) << 4) | 32'(cmd));
        wait_idle(cyc);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] fsave;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check({data_w2, data_w1, data_w0} == '0, "R1", "data after reset",
              {data_w2, data_w1, data_w0}, '0);
        check(func_word == '0, "R1", "func after reset", 96'(func_word), '0);

        for (int i = 0; i < NV; i++) begin
            set_image(img(VEC[i].mac, VEC[i].vid, VEC[i].pm, VEC[i].st));
            run(VEC[i].cmd, VEC[i].pen, VEC[i].pnum, cyc);
            check(func_word[12] == VEC[i].xfull, $sformatf("R%0d vec%0d", VEC[i].req, i),
                  "full flag", 96'(func_word[12]), 96'(VEC[i].xfull));
            check({data_w2, data_w1, data_w0} == img(VEC[i].xmac, VEC[i].xvid, VEC[i].xpm, VEC[i].xst),
                  $sformatf("R%0d vec%0d", VEC[i].req, i), "image",
                  {data_w2, data_w1, data_w0}, img(VEC[i].xmac, VEC[i].xvid, VEC[i].xpm, VEC[i].xst));
        end

        // R3 latency, measured on a load into an empty table
        set_image(img(MA, 12'd1, 7'h02, 4'hF));
        run(4'd2, 1'b0, 3'd0, cyc);
        check(cyc == DEPTH + 1, "R3", "busy cycles", 96'(cyc), 96'(DEPTH + 1));

        // R2 raw word layout of a returned entry
        set_image('0);
        run(4'd4, 1'b0, 3'd0, cyc);
        check(data_w0 == 32'h2C3D4E5F, "R2", "word0", 96'(data_w0), 96'h2C3D4E5F);
        check(data_w1 == 32'h00020A1B, "R2", "word1", 96'(data_w1), 96'h00020A1B);
        check(data_w2 == 32'h0000010F, "R2", "word2", 96'(data_w2), 96'h0000010F);

        // R3 function write without bit 31 starts nothing
        fsave = func_word;
        wr(2'd3, 32'h0000_0001);
        check(func_word == fsave, "R3", "func after no-start write", 96'(func_word), 96'(fsave));
        set_image('0);
        run(4'd4, 1'b0, 3'd0, cyc);
        check({data_w2, data_w1, data_w0} == img(MA, 12'd1, 7'h02, 4'hF), "R3",
              "table after no-start flush", {data_w2, data_w1, data_w0}, img(MA, 12'd1, 7'h02, 4'hF));

        // R10 writes during busy are ignored
        set_image(img(MB, 12'd1, 7'h04, 4'h7));
        wr(2'd3, 32'h8000_0002);
        check(func_word[31] == 1'b1, "R10", "busy after start", 96'(func_word[31]), 96'd1);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd3, 32'h8000_0001);
        wait_idle(cyc);
        check(data_w0 == MB[31:0], "R10", "word0 after busy write", 96'(data_w0), 96'(MB[31:0]));
        check(func_word[3:0] == 4'd2, "R10", "cmd after busy write", 96'(func_word[3:0]), 96'd2);
        set_image(img(MA, 12'd1, 7'h00, 4'h0));
        run(4'd4, 1'b0, 3'd0, cyc);
        check({data_w2, data_w1, data_w0} == img(MB, 12'd1, 7'h04, 4'h7), "R10",
              "no flush ran", {data_w2, data_w1, data_w0}, img(MB, 12'd1, 7'h04, 4'h7));

        // R1 reset in the middle of use empties the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check({data_w2, data_w1, data_w0} == '0, "R1", "data after second reset",
              {data_w2, data_w1, data_w0}, '0);
        check(func_word == '0, "R1", "func after second reset", 96'(func_word), '0);
        run(4'd4, 1'b0, 3'd0, cyc);
        check({data_w2, data_w1, data_w0} == '0, "R1", "table empty after reset",
              {data_w2, data_w1, data_w0}, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule